// File: doc/BRIEF.md
# IR Remote Timer Control Unit

This block is the control and timebase front end of an infrared remote transmitter. Software reaches it through a small register port with two 16-bit registers: a clock configuration register and a control register. The configuration picks one of four clock sources and a power-of-two division from 1 to 32768. A free-running prescaler turns the chosen source into a single-cycle counting tick.

The control register holds the module enable, a software reset, a counter preset request and a run/stop bit. It also stores three waveform option bits (output invert, buffer enable, mode) that are driven out unchanged. Two up-counters, a 16-bit data-signal counter and an 8-bit carrier counter, advance on ticks while running.

Each clock source arrives as an enable strobe synchronous to `clk`. A source "edge" is one cycle with its strobe high. The register port is a plain single-cycle write strobe with a combinational read path. No data stream crosses the block, so it has no valid/ready handshake.

Top module: `ir_tx_ctrl`

## Requirements
- R1: The configuration register (address 0) holds the source code in bits 1:0. Code k makes `src_en[k]` the counted source, and strobes on the other sources are not counted.
- R2: The configuration register holds the divide code N in bits 11:8. While enabled, `tick` pulses together with every 2^N-th selected strobe, counted since the enable was set. While the enable is 0, the prescaler is held clear and `tick` stays 0.
- R3: A write to the configuration register takes effect only when the enable bit is 0 before the write. While the enable bit is 1, the register keeps its value.
- R4: Writing 1 to control bit 9 (preset) sets both counters to zero on the next tick. Writing 0 to that bit changes nothing.
- R5: Control bit 9 reads 1 from the cycle after the accepted preset write until the tick that clears the counters, and 0 after that.
- R6: A preset write is ignored unless the enable bit (control bit 0) was already 1 before the write.
- R7: Writing 1 to control bit 1 (software reset) clears the run bit, the pending preset and both counters, and leaves the configuration register unchanged. Bit 1 always reads 0.
- R8: Control bit 8 (run) is written directly and read back. The counters advance by one per tick while it is 1 and hold while it is 0.
- R9: All bits reset to 0. Control bits 2, 3 and 4 are stored and read back and drive `mode_sel`, `buf_en` and `out_inv`. Reserved bits (control 15:10 and 7:5, configuration 15:12 and 7:2) read 0.
- R10: The data counter wraps modulo 2^16 and the carrier counter wraps modulo 2^8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 1 | Register select: 0 configuration, 1 control |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the register selected by `reg_addr` |
| src_en | input | 4 | Per-source clock enable strobes |
| tick | output | 1 | Counting tick enable |
| data_cnt | output | 16 | Data-signal counter value |
| carr_cnt | output | 8 | Carrier counter value |
| run | output | 1 | Counters running |
| out_inv | output | 1 | Stored output-invert option |
| buf_en | output | 1 | Stored buffer-enable option |
| mode_sel | output | 1 | Stored mode option |

## Verification
The embedded assertions watch, on every cycle, that:
- the configuration holds while enabled;
- a preset only rises when the enable was already set, and drops on the tick that serves it;
- a software reset leaves run and preset low;
- the counters clear, hold or step by exactly one;
- ticks at a division above one never come on two cycles in a row.

Only the bench's scenarios can show the rest. That covers the exact tick position for a given divide code and the source selection. It also covers the read-back layout, the rejected preset while disabled, that the configuration survives a software reset, and counter wrap-around after long runs.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
  localparam int REG_W = 16;

  localparam logic ADDR_CFG = 1'b0;
  localparam logic ADDR_CTL = 1'b1;

  // control register bit positions
  localparam int CTL_EN     = 0;
  localparam int CTL_SWRST  = 1;
  localparam int CTL_MODE   = 2;
  localparam int CTL_BUF    = 3;
  localparam int CTL_INV    = 4;
  localparam int CTL_RUN    = 8;
  localparam int CTL_PRESET = 9;

  // configuration register field positions
  localparam int CFG_SRC_LSB = 0;
  localparam int CFG_DIV_LSB = 8;

  typedef enum logic [1:0] {
    SRC_INTERNAL = 2'd0,
    SRC_OSC_A    = 2'd1,
    SRC_OSC_B    = 2'd2,
    SRC_EXTERNAL = 2'd3
  } clk_src_e;
endpackage

// File: rtl/ir_clk_prescaler.sv
module ir_clk_prescaler #(
  parameter int NUM_SRC = 4,
  parameter int PRE_W   = 15,
  parameter int DIV_W   = 4,
  localparam int SEL_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [DIV_W-1:0]   div_sel,
  output logic               tick
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;
  logic             sel_pulse;

  assign sel_pulse = src_en[src_sel];
  assign mask      = ~({PRE_W{1'b1}} << div_sel);
  assign tick      = enable && sel_pulse && ((cnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!enable)    cnt_q <= '0;
    else if (sel_pulse)  cnt_q <= cnt_q + 1'b1;
  end

  // R2: with a division above one, ticks are never back to back
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_sel != '0) |=> !tick);
endmodule

// File: rtl/ir_ctrl_regs.sv
module ir_ctrl_regs
  import ir_tx_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             tick,
  output logic [SEL_W-1:0] src_sel,
  output logic [DIV_W-1:0] div_sel,
  output logic             enable,
  output logic             run,
  output logic             mode_sel,
  output logic             buf_en,
  output logic             out_inv,
  output logic             clr_cnt
);
  logic [SEL_W-1:0] src_q;
  logic [DIV_W-1:0] div_q;
  logic en_q, run_q, mode_q, buf_q, inv_q, preset_q;
  logic cfg_wr, ctl_wr, swrst_wr;
  logic unused_wbits;

  assign cfg_wr   = reg_wr && (reg_addr == ADDR_CFG);
  assign ctl_wr   = reg_wr && (reg_addr == ADDR_CTL);
  assign swrst_wr = ctl_wr && reg_wdata[CTL_SWRST];
  assign clr_cnt  = swrst_wr || (preset_q && tick);
  assign unused_wbits = ^{reg_wdata[7:5], reg_wdata[15:12]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; div_q <= '0; en_q <= 1'b0; run_q <= 1'b0;
      mode_q <= 1'b0; buf_q <= 1'b0; inv_q <= 1'b0; preset_q <= 1'b0;
    end else begin
      if (cfg_wr && !en_q) begin
        src_q <= reg_wdata[CFG_SRC_LSB +: SEL_W];
        div_q <= reg_wdata[CFG_DIV_LSB +: DIV_W];
      end
      if (preset_q && tick) preset_q <= 1'b0;
      if (ctl_wr) begin
        en_q   <= reg_wdata[CTL_EN];
        mode_q <= reg_wdata[CTL_MODE];
        buf_q  <= reg_wdata[CTL_BUF];
        inv_q  <= reg_wdata[CTL_INV];
        run_q  <= reg_wdata[CTL_RUN];
        if (reg_wdata[CTL_PRESET] && en_q) preset_q <= 1'b1;
        if (reg_wdata[CTL_SWRST]) begin
          run_q    <= 1'b0;
          preset_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CFG) begin
      reg_rdata[CFG_SRC_LSB +: SEL_W] = src_q;
      reg_rdata[CFG_DIV_LSB +: DIV_W] = div_q;
    end else begin
      reg_rdata[CTL_EN]     = en_q;
      reg_rdata[CTL_MODE]   = mode_q;
      reg_rdata[CTL_BUF]    = buf_q;
      reg_rdata[CTL_INV]    = inv_q;
      reg_rdata[CTL_RUN]    = run_q;
      reg_rdata[CTL_PRESET] = preset_q;
    end
  end

  assign src_sel  = src_q;
  assign div_sel  = div_q;
  assign enable   = en_q;
  assign run      = run_q;
  assign mode_sel = mode_q;
  assign buf_en   = buf_q;
  assign out_inv  = inv_q;

  // R3: configuration frozen while enabled
  p_cfg_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable({src_q, div_q}));
  // R6: a preset only becomes pending if the enable was already set
  p_preset_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(preset_q) |-> $past(en_q));
  // R5: the serving tick drops the busy flag
  p_preset_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_q && tick && !reg_wr) |=> !preset_q);
  // R7: software reset leaves run and preset low
  p_swrst_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_wr |=> (!run_q && !preset_q));
endmodule

// File: rtl/ir_tick_counter.sv
module ir_tick_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (adv)  cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;

  // R4: a clear request empties the counter
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  // R8: no tick while running means no change
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> $stable(count));
  // R10: each step is exactly one, modulo the width
  p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (count == W'($past(count) + 1'b1)));
endmodule

// File: rtl/ir_tx_ctrl.sv
module ir_tx_ctrl
  import ir_tx_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int PRE_W   = 15,
  parameter int DIV_W   = 4,
  parameter int DATA_W  = 16,
  parameter int CARR_W  = 8,
  localparam int SEL_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [NUM_SRC-1:0] src_en,
  output logic               tick,
  output logic [DATA_W-1:0]  data_cnt,
  output logic [CARR_W-1:0]  carr_cnt,
  output logic               run,
  output logic               out_inv,
  output logic               buf_en,
  output logic               mode_sel
);
  logic [SEL_W-1:0] src_sel;
  logic [DIV_W-1:0] div_sel;
  logic             enable;
  logic             clr_cnt;
  logic             adv;

  ir_ctrl_regs #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
    .src_sel(src_sel), .div_sel(div_sel), .enable(enable), .run(run),
    .mode_sel(mode_sel), .buf_en(buf_en), .out_inv(out_inv),
    .clr_cnt(clr_cnt)
  );

  ir_clk_prescaler #(.NUM_SRC(NUM_SRC), .PRE_W(PRE_W), .DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .enable(enable), .src_en(src_en),
    .src_sel(src_sel), .div_sel(div_sel), .tick(tick)
  );

  assign adv = tick && run;

  ir_tick_counter #(.W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .clr(clr_cnt), .adv(adv), .count(data_cnt)
  );

  ir_tick_counter #(.W(CARR_W)) u_carr (
    .clk(clk), .rst_n(rst_n), .clr(clr_cnt), .adv(adv), .count(carr_cnt)
  );
endmodule

// File: tb/ir_tx_ctrl_test.sv
module ir_tx_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  src_en = '0;
  logic        tick;
  logic [15:0] data_cnt;
  logic [7:0]  carr_cnt;
  logic        run, out_inv, buf_en, mode_sel;

  int checks = 0;
  int errors = 0;
  bit sb_on = 1'b0;
  bit sb_arm = 1'b0;
  int mdl_cnt = 0;

  typedef struct { int dval; int cval; } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  ir_tx_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_en(src_en),
    .tick(tick), .data_cnt(data_cnt), .carr_cnt(carr_cnt), .run(run),
    .out_inv(out_inv), .buf_en(buf_en), .mode_sel(mode_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic a, input logic [15:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, {16'h0, reg_rdata}, {16'h0, exp});
  endtask

  // driver: one strobe on source idx; pushes expected counts when a counted tick is due
  task automatic pulse(input int idx, input bit exp_tick, input string tag);
    @(negedge clk);
    src_en = '0;
    src_en[idx] = 1'b1;
    #1;
    chk(tag, {31'h0, tick}, {31'h0, exp_tick});
    if (exp_tick && sb_on) begin
      mdl_cnt++;
      sb_q.push_back('{dval: mdl_cnt % 65536, cval: mdl_cnt % 256});
    end
    @(negedge clk);
    src_en = '0;
  endtask

  // monitor: compares counters after every counted tick
  always @(posedge clk) sb_arm <= sb_on && tick && run;
  always @(negedge clk) begin
    if (sb_arm) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected count step actual=%0d expected=none", data_cnt);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk("R8 R10 data counter", {16'h0, data_cnt}, e.dval);
        chk("R10 carrier counter", {24'h0, carr_cnt}, e.cval);
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    rd_chk("R9 cfg reset", 1'b0, 16'h0000);
    rd_chk("R9 ctl reset", 1'b1, 16'h0000);
    chk("R9 counters reset", {8'h0, data_cnt, carr_cnt}, 32'h0);

    // R3 writable while disabled; reserved bits read 0 (R9)
    wr(1'b0, 16'hF2FD);
    rd_chk("R3 R9 cfg write disabled", 1'b0, 16'h0201);
    wr(1'b1, 16'hFCFD);
    rd_chk("R9 ctl readback", 1'b1, 16'h001D);
    chk("R9 option pins", {29'h0, out_inv, buf_en, mode_sel}, 32'h7);
    wr(1'b0, 16'h0F03);
    rd_chk("R3 cfg locked", 1'b0, 16'h0201);

    // R1 R2: src 1, divide by 4, running
    wr(1'b1, 16'h011D);
    chk("R8 run pin", {31'h0, run}, 32'h1);
    sb_on = 1'b1;
    for (int i = 0; i < 4; i++) pulse(0, 1'b0, "R1 unselected source");
    for (int i = 1; i <= 8; i++) pulse(1, (i % 4) == 0, "R2 divide by 4");
    sb_on = 1'b0;
    chk("R2 two ticks counted", {16'h0, data_cnt}, 32'd2);

    // R4 R5 preset
    wr(1'b1, 16'h031D);
    rd_chk("R5 preset busy", 1'b1, 16'h031D);
    wr(1'b1, 16'h011D);
    rd_chk("R4 preset write 0 no effect", 1'b1, 16'h031D);
    chk("R4 counter kept before tick", {16'h0, data_cnt}, 32'd2);
    for (int i = 1; i <= 3; i++) pulse(1, 1'b0, "R2 no tick");
    rd_chk("R5 busy until tick", 1'b1, 16'h031D);
    pulse(1, 1'b1, "R2 preset tick");
    chk("R4 preset cleared", {8'h0, data_cnt, carr_cnt}, 32'h0);
    rd_chk("R5 preset done", 1'b1, 16'h011D);

    // R6 preset ignored while disabled; R2 no tick disabled
    wr(1'b1, 16'h0100);
    wr(1'b1, 16'h0300);
    rd_chk("R6 preset rejected", 1'b1, 16'h0100);
    for (int i = 0; i < 4; i++) pulse(1, 1'b0, "R2 disabled no tick");

    // R1 R10: src 2, divide by 1, long run
    wr(1'b0, 16'h0002);
    rd_chk("R3 cfg write after disable", 1'b0, 16'h0002);
    wr(1'b1, 16'h0101);
    mdl_cnt = 0;
    sb_on = 1'b1;
    for (int i = 0; i < 300; i++) pulse(2, 1'b1, "R2 divide by 1");
    pulse(3, 1'b0, "R1 source 3 unselected");
    sb_on = 1'b0;
    chk("R10 carrier wrap", {24'h0, carr_cnt}, 32'd44);

    // R7 software reset with run requested
    wr(1'b1, 16'h0103);
    rd_chk("R7 swrst run cleared", 1'b1, 16'h0001);
    chk("R7 counters cleared", {8'h0, data_cnt, carr_cnt}, 32'h0);
    rd_chk("R7 cfg kept", 1'b0, 16'h0002);
    wr(1'b1, 16'h0201);
    rd_chk("R5 preset pending", 1'b1, 16'h0201);
    wr(1'b1, 16'h0003);
    rd_chk("R7 swrst clears preset", 1'b1, 16'h0001);

    // R8 stop holds, run advances
    pulse(2, 1'b1, "R8 tick while stopped");
    chk("R8 hold when stopped", {16'h0, data_cnt}, 32'd0);
    wr(1'b1, 16'h0101);
    pulse(2, 1'b1, "R8 tick while running");
    chk("R8 advance when running", {16'h0, data_cnt}, 32'd1);

    // R1 external source, R3 configuration path
    wr(1'b1, 16'h0000);
    wr(1'b0, 16'h0003);
    wr(1'b1, 16'h0101);
    pulse(2, 1'b0, "R1 source 2 ignored");
    pulse(3, 1'b1, "R1 source 3 counted");
    chk("R1 external count", {16'h0, data_cnt}, 32'd2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule